// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single words between two ports that run on unrelated clocks, next to a FIFO and outside it. Each port presents a chip select (active low), a direction bit, an enable and a mailbox select. Together these choose FIFO traffic, mailbox traffic or nothing. Port A writes the forward mailbox (slot 1), which port B reads. Port B writes the return mailbox (slot 2), which port A reads. The FIFO datapath is not part of the block. Its write strobe (port A) and read strobe (port B) come out decoded, and port B's output mux takes the FIFO output word as its second source.

Each mailbox has an empty flag, high when empty and low when full. Each port sees both flags in its own clock domain. The writing side and the reading side each own one toggle bit. The flag on either side compares the local toggle with a copy of the far toggle, brought across by a synchronizer. A write to a full slot is dropped, so unread data is never overwritten. A read of an empty slot changes nothing.

The data outputs are a data word plus an output enable, not tri-state pins. When the enable is low the word is forced to zero.

Top module: `mbx_pair`

## Requirements
- R1: After reset, all four empty flags (`a_mb1_empty`, `a_mb2_empty`, `b_mb1_empty`, `b_mb2_empty`) read 1, and both mailbox registers read back as zero.
- R2: On port A, `a_dir`=1 means write. With `a_cs_n`=0, `a_dir`=1, `a_en`=1 and `a_mbx_sel`=1, a rising `clk_a` stores `a_din` in slot 1, and `a_mb1_empty` is 0 after that edge. With `a_mbx_sel`=0, the same inputs drive `a_fifo_wr` high combinationally and leave slot 1 and its flag unchanged.
- R3: On port B, `b_dir`=1 means read. With `b_cs_n`=0, `b_dir`=1, `b_en`=1 and `b_mbx_sel`=1, a rising `clk_b` edge that finds slot 1 full makes `b_mb1_empty` 1 after that edge. `b_mb1_empty` never rises without such a read.
- R4: With `b_cs_n`=0, `b_dir`=0, `b_en`=1 and `b_mbx_sel`=1, a rising `clk_b` stores `b_din` in slot 2 and clears `b_mb2_empty`. With `a_cs_n`=0, `a_dir`=0, `a_en`=1 and `a_mbx_sel`=1, a rising `clk_a` edge that finds slot 2 full reads it and sets `a_mb2_empty`.
- R5: A mailbox write decoded while the writer-side flag of that slot is 0 is ignored. The stored word and the flag both stay as they were.
- R6: `a_oe` = !`a_cs_n` & !`a_dir`, and when `a_oe` is high, `a_dout` shows slot 2. `b_oe` = !`b_cs_n` & `b_dir`, and when `b_oe` is high, `b_dout` shows slot 1 if `b_mbx_sel`=1 and `fifo_q` if `b_mbx_sel`=0. A port's data output is zero while its enable output is low.
- R7: While a port's enable input is low, no clock edge of that port changes a mailbox or a flag, and that port's FIFO strobe stays low.
- R8: After an accepted write or read, the flag in the other domain changes after the second rising edge of that domain's clock that follows the event, and not before.
- R9: A mailbox read decoded while the slot is empty leaves every flag unchanged. `b_fifo_rd` is high exactly when `b_cs_n`=0, `b_dir`=1, `b_en`=1 and `b_mbx_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to `clk_a` |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously in each domain |
| a_cs_n | input | 1 | Port A select, active low |
| a_dir | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A operation enable |
| a_mbx_sel | input | 1 | Port A target: 1 mailbox, 0 FIFO |
| a_din | input | WIDTH | Port A write word |
| a_dout | output | WIDTH | Port A read word (slot 2), zero when not enabled |
| a_oe | output | 1 | Port A output enable |
| a_fifo_wr | output | 1 | Decoded FIFO write strobe |
| a_mb1_empty | output | 1 | Slot 1 empty flag, `clk_a` domain |
| a_mb2_empty | output | 1 | Slot 2 empty flag, `clk_a` domain |
| b_cs_n | input | 1 | Port B select, active low |
| b_dir | input | 1 | Port B direction: 1 read, 0 write |
| b_en | input | 1 | Port B operation enable |
| b_mbx_sel | input | 1 | Port B target: 1 mailbox, 0 FIFO |
| b_din | input | WIDTH | Port B write word |
| fifo_q | input | WIDTH | FIFO output register word, second source for port B |
| b_dout | output | WIDTH | Port B read word, zero when not enabled |
| b_oe | output | 1 | Port B output enable |
| b_fifo_rd | output | 1 | Decoded FIFO read strobe |
| b_mb1_empty | output | 1 | Slot 1 empty flag, `clk_b` domain |
| b_mb2_empty | output | 1 | Slot 2 empty flag, `clk_b` domain |

## Verification
The flag assertions assume that each port's controls are stable around that port's own clock edge. They also assume that the far toggle reaches the near side only through the synchronizer, so that one side's flag can move in only one direction between its own events. The bench changes port A inputs only on `clk_a` falling edges and port B inputs only on `clk_b` falling edges. The two clocks are placed so that a rising edge of one never lands within 5 ns of a rising edge of the other. This keeps every two-edge latency count exact and lets outputs be sampled 2 ns after an edge. The decode table is walked while reset holds every flop, so the combinational strobes and muxes are checked without side effects on the mailboxes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Control bundle presented by one port each cycle.
  typedef struct packed {
    logic cs_n;   // port select, active low
    logic dir;    // direction bit, polarity set per port
    logic en;     // operation enable
    logic sel;    // 1: mailbox, 0: FIFO
  } port_ctl_t;

  // Direction level that means "write" on each port.
  localparam logic PORT_A_WR_LEVEL = 1'b1;
  localparam logic PORT_B_WR_LEVEL = 1'b0;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter logic WR_LEVEL      = 1'b1,
  parameter logic FIFO_ON_WRITE = 1'b1
) (
  input  port_ctl_t ctl,
  output logic      oe,
  output logic      mail_wr,
  output logic      mail_rd,
  output logic      fifo_stb
);

  logic wr_dir;
  logic act;

  always_comb begin
    wr_dir   = (ctl.dir == WR_LEVEL);
    act      = !ctl.cs_n && ctl.en;
    oe       = !ctl.cs_n && !wr_dir;
    mail_wr  = act && ctl.sel && wr_dir;
    mail_rd  = act && ctl.sel && !wr_dir;
    fifo_stb = act && !ctl.sel && (wr_dir == FIFO_ON_WRITE);
  end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_req,
  output logic [WIDTH-1:0] rdata,
  output logic             wside_empty,
  output logic             rside_empty
);

  logic [WIDTH-1:0] data_q, data_d;
  logic             wtog_q, wtog_d;
  logic             rtog_q, rtog_d;
  logic             rtog_at_w;
  logic             wtog_at_r;
  logic             wr_take;
  logic             rd_take;

  // Far toggles brought into the local domain.
  mbx_sync #(.STAGES(SYNC_STAGES)) u_r2w (
    .clk  (wclk),
    .rst_n(wrst_n),
    .d    (rtog_q),
    .q    (rtog_at_w)
  );

  mbx_sync #(.STAGES(SYNC_STAGES)) u_w2r (
    .clk  (rclk),
    .rst_n(rrst_n),
    .d    (wtog_q),
    .q    (wtog_at_r)
  );

  assign wside_empty = (wtog_q == rtog_at_w);
  assign rside_empty = (rtog_q == wtog_at_r);
  assign rdata       = data_q;

  // Writer domain: next state.
  always_comb begin
    wr_take = wr_req && wside_empty;
    wtog_d  = wtog_q ^ wr_take;
    data_d  = data_q;
    if (wr_take) begin
      data_d = wdata;
    end
  end

  // Writer domain: registers.
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wtog_q <= 1'b0;
      data_q <= '0;
    end else begin
      wtog_q <= wtog_d;
      if (wr_take) begin
        data_q <= data_d;
      end
    end
  end

  // Reader domain: next state.
  always_comb begin
    rd_take = rd_req && !rside_empty;
    rtog_d  = rtog_q ^ rd_take;
  end

  // Reader domain: registers.
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rtog_q <= 1'b0;
    end else begin
      rtog_q <= rtog_d;
    end
  end

  AST_WRITE_FILLS: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_req && wside_empty) |=> !wside_empty); // R2
  AST_FULL_WRITE_DROPPED: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_req && !wside_empty) |=> ($stable(data_q) && !wside_empty)); // R5
  AST_READ_EMPTIES: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_req && !rside_empty) |=> rside_empty); // R3
  AST_NO_SPURIOUS_EMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!rd_req && !rside_empty) |=> !rside_empty); // R3
  AST_EMPTY_READ_NOP: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_req && rside_empty) |=> $stable(rtog_q)); // R9

endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic             a_cs_n,
  input  logic             a_dir,
  input  logic             a_en,
  input  logic             a_mbx_sel,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_oe,
  output logic             a_fifo_wr,
  output logic             a_mb1_empty,
  output logic             a_mb2_empty,
  input  logic             b_cs_n,
  input  logic             b_dir,
  input  logic             b_en,
  input  logic             b_mbx_sel,
  input  logic [WIDTH-1:0] b_din,
  input  logic [WIDTH-1:0] fifo_q,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_oe,
  output logic             b_fifo_rd,
  output logic             b_mb1_empty,
  output logic             b_mb2_empty
);

  logic             rst_a_n;
  logic             rst_b_n;
  port_ctl_t        a_ctl;
  port_ctl_t        b_ctl;
  logic             a_mail_wr, a_mail_rd;
  logic             b_mail_wr, b_mail_rd;
  logic [WIDTH-1:0] fwd_word;
  logic [WIDTH-1:0] ret_word;

  // Per-domain reset: asserted at once, released on the domain clock.
  mbx_sync #(.STAGES(SYNC_STAGES)) u_rst_a (
    .clk  (clk_a),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_a_n)
  );

  mbx_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
    .clk  (clk_b),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_b_n)
  );

  assign a_ctl = {a_cs_n, a_dir, a_en, a_mbx_sel};
  assign b_ctl = {b_cs_n, b_dir, b_en, b_mbx_sel};

  mbx_port_decode #(
    .WR_LEVEL     (PORT_A_WR_LEVEL),
    .FIFO_ON_WRITE(1'b1)
  ) u_dec_a (
    .ctl     (a_ctl),
    .oe      (a_oe),
    .mail_wr (a_mail_wr),
    .mail_rd (a_mail_rd),
    .fifo_stb(a_fifo_wr)
  );

  mbx_port_decode #(
    .WR_LEVEL     (PORT_B_WR_LEVEL),
    .FIFO_ON_WRITE(1'b0)
  ) u_dec_b (
    .ctl     (b_ctl),
    .oe      (b_oe),
    .mail_wr (b_mail_wr),
    .mail_rd (b_mail_rd),
    .fifo_stb(b_fifo_rd)
  );

  // Slot 1: written on port A, read on port B.
  mbx_slot #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_slot_fwd (
    .wclk       (clk_a),
    .wrst_n     (rst_a_n),
    .wr_req     (a_mail_wr),
    .wdata      (a_din),
    .rclk       (clk_b),
    .rrst_n     (rst_b_n),
    .rd_req     (b_mail_rd),
    .rdata      (fwd_word),
    .wside_empty(a_mb1_empty),
    .rside_empty(b_mb1_empty)
  );

  // Slot 2: written on port B, read on port A.
  mbx_slot #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_slot_ret (
    .wclk       (clk_b),
    .wrst_n     (rst_b_n),
    .wr_req     (b_mail_wr),
    .wdata      (b_din),
    .rclk       (clk_a),
    .rrst_n     (rst_a_n),
    .rd_req     (a_mail_rd),
    .rdata      (ret_word),
    .wside_empty(b_mb2_empty),
    .rside_empty(a_mb2_empty)
  );

  // Output muxes.
  always_comb begin
    a_dout = '0;
    if (a_oe) begin
      a_dout = ret_word;
    end
  end

  always_comb begin
    b_dout = '0;
    if (b_oe) begin
      b_dout = b_mbx_sel ? fwd_word : fifo_q;
    end
  end

  AST_A_IDLE_NO_FIFO: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !a_en |-> !a_fifo_wr); // R7
  AST_B_IDLE_KEEPS_FWD: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (!b_en && !b_mb1_empty) |=> !b_mb1_empty); // R7

endmodule

// File: tb/mbx_pair_test.sv
module mbx_pair_test;

  localparam int W = 36;

  // {cs_n,dir,en,sel}
  localparam logic [3:0] IDLE       = 4'b1000;
  localparam logic [3:0] A_MAIL_WR  = 4'b0111;
  localparam logic [3:0] A_FIFO_WR  = 4'b0110;
  localparam logic [3:0] A_MAIL_RD  = 4'b0011;
  localparam logic [3:0] A_PEEK     = 4'b0001;
  localparam logic [3:0] B_MAIL_RD  = 4'b0111;
  localparam logic [3:0] B_MAIL_WR  = 4'b0011;
  localparam logic [3:0] B_PEEK     = 4'b0101;
  localparam logic [3:0] B_FIFO_PK  = 4'b0100;
  localparam logic [3:0] B_WR_OFF   = 4'b0001;

  localparam logic [W-1:0] D1 = 36'hA_5A5A_0001;
  localparam logic [W-1:0] DX = 36'h1_1111_1111;
  localparam logic [W-1:0] D2 = 36'h5_A5A5_0002;
  localparam logic [W-1:0] D3 = 36'hC_0FFE_E003;
  localparam logic [W-1:0] FQ = 36'h3_F1F0_0001;

  // Decode table: [11:8] A ctl, [7:6] exp {a_oe,a_fifo_wr},
  //               [5:2] B ctl, [1:0] exp {b_oe,b_fifo_rd}
  localparam int NTAB = 8;
  localparam logic [11:0] DEC_TAB [NTAB] = '{
    12'b1111_00_1110_00,
    12'b0110_01_0110_11,
    12'b0111_00_0111_10,
    12'b0011_10_0010_00,
    12'b0000_10_0100_10,
    12'b0100_00_0011_00,
    12'b0010_10_1010_00,
    12'b1010_00_0101_10
  };

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b0;
  logic a_cs_n, a_dir, a_en, a_mbx_sel;
  logic b_cs_n, b_dir, b_en, b_mbx_sel;
  logic [W-1:0] a_din, b_din, fifo_q;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, a_fifo_wr, a_mb1_empty, a_mb2_empty;
  logic b_oe, b_fifo_rd, b_mb1_empty, b_mb2_empty;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk_a = ~clk_a;   // 50 MHz, rising edges at 10 + 20k ns
  always #15 clk_b = ~clk_b;   // rising edges at 15 + 30m ns

  mbx_pair #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_dir(a_dir), .a_en(a_en), .a_mbx_sel(a_mbx_sel),
    .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe), .a_fifo_wr(a_fifo_wr),
    .a_mb1_empty(a_mb1_empty), .a_mb2_empty(a_mb2_empty),
    .b_cs_n(b_cs_n), .b_dir(b_dir), .b_en(b_en), .b_mbx_sel(b_mbx_sel),
    .b_din(b_din), .fifo_q(fifo_q), .b_dout(b_dout), .b_oe(b_oe),
    .b_fifo_rd(b_fifo_rd), .b_mb1_empty(b_mb1_empty), .b_mb2_empty(b_mb2_empty)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_a(input logic [3:0] c);
    {a_cs_n, a_dir, a_en, a_mbx_sel} = c;
  endtask

  task automatic set_b(input logic [3:0] c);
    {b_cs_n, b_dir, b_en, b_mbx_sel} = c;
  endtask

  // Drive on the falling edge, act on the rising edge, return 2 ns later.
  task automatic a_cycle(input logic [3:0] c, input logic [W-1:0] d);
    @(negedge clk_a);
    set_a(c);
    a_din = d;
    @(posedge clk_a);
    #2;
    set_a(IDLE);
  endtask

  task automatic b_cycle(input logic [3:0] c, input logic [W-1:0] d);
    @(negedge clk_b);
    set_b(c);
    b_din = d;
    @(posedge clk_b);
    #2;
    set_b(IDLE);
  endtask

  task automatic b_edge();
    @(posedge clk_b);
    #2;
  endtask

  task automatic a_edge();
    @(posedge clk_a);
    #2;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    set_a(IDLE);
    set_b(IDLE);
    a_din  = '0;
    b_din  = '0;
    fifo_q = FQ;

    // Decode table walked while reset holds all flops (R6, R7, R9, R2).
    #25;
    for (int i = 0; i < NTAB; i++) begin
      logic [11:0] v;
      v = DEC_TAB[i];
      set_a(v[11:8]);
      set_b(v[5:2]);
      #1;
      check("R6_R2_R7", $sformatf("table %0d port A {oe,fifo_wr}", i),
            W'({a_oe, a_fifo_wr}), W'(v[7:6]));
      check("R6_R9_R7", $sformatf("table %0d port B {oe,fifo_rd}", i),
            W'({b_oe, b_fifo_rd}), W'(v[1:0]));
      check("R6", $sformatf("table %0d b_dout", i), b_dout,
            v[1] ? (v[2] ? '0 : FQ) : '0);
      check("R6", $sformatf("table %0d a_dout", i), a_dout, '0);
    end
    set_a(IDLE);
    set_b(IDLE);

    @(negedge clk_a);
    rst_n = 1'b1;
    repeat (4) b_edge();

    // R1: reset state
    check("R1", "flags {a1,a2,b1,b2}",
          W'({a_mb1_empty, a_mb2_empty, b_mb1_empty, b_mb2_empty}), W'(4'hF));
    set_a(A_PEEK);
    set_b(B_PEEK);
    #1;
    check("R1", "slot 2 via a_dout", a_dout, '0);
    check("R1", "slot 1 via b_dout", b_dout, '0);
    set_a(IDLE);
    set_b(IDLE);

    // R2, R8: port A mail write and crossing latency
    a_cycle(A_MAIL_WR, D1);
    check("R2", "a_mb1_empty after write", W'(a_mb1_empty), W'(1'b0));
    check("R8", "b_mb1_empty right after write", W'(b_mb1_empty), W'(1'b1));
    b_edge();
    check("R8", "b_mb1_empty after 1st clk_b edge", W'(b_mb1_empty), W'(1'b1));
    b_edge();
    check("R8", "b_mb1_empty after 2nd clk_b edge", W'(b_mb1_empty), W'(1'b0));
    set_b(B_PEEK);
    #1;
    check("R6", "b_dout shows slot 1", b_dout, D1);
    set_b(IDLE);

    // R5: write to full slot is dropped
    a_cycle(A_MAIL_WR, DX);
    check("R5", "a_mb1_empty still full", W'(a_mb1_empty), W'(1'b0));
    repeat (3) b_edge();
    set_b(B_PEEK);
    #1;
    check("R5", "slot 1 kept first word", b_dout, D1);
    set_b(IDLE);

    // R7: enable low means no operation
    b_cycle(B_PEEK, '0);
    b_cycle(B_PEEK, '0);
    check("R7", "b_mb1_empty with read enable low", W'(b_mb1_empty), W'(1'b0));
    b_cycle(B_WR_OFF, D2);
    check("R7", "b_mb2_empty with write enable low", W'(b_mb2_empty), W'(1'b1));
    repeat (3) a_edge();
    check("R7", "a_mb2_empty with write enable low", W'(a_mb2_empty), W'(1'b1));

    // R3, R8: port B read of slot 1
    b_cycle(B_MAIL_RD, '0);
    check("R3", "b_mb1_empty after read", W'(b_mb1_empty), W'(1'b1));
    check("R8", "a_mb1_empty right after read", W'(a_mb1_empty), W'(1'b0));
    a_edge();
    check("R8", "a_mb1_empty after 1st clk_a edge", W'(a_mb1_empty), W'(1'b0));
    a_edge();
    check("R8", "a_mb1_empty after 2nd clk_a edge", W'(a_mb1_empty), W'(1'b1));

    // R9: read of empty slot 1 changes nothing
    b_cycle(B_MAIL_RD, '0);
    check("R9", "b_mb1_empty after empty read", W'(b_mb1_empty), W'(1'b1));
    repeat (3) a_edge();
    check("R9", "a_mb1_empty after empty read", W'(a_mb1_empty), W'(1'b1));

    // R2: FIFO write with mailbox select low leaves slot 1 alone
    a_cycle(A_FIFO_WR, DX);
    check("R2", "a_mb1_empty after FIFO write", W'(a_mb1_empty), W'(1'b1));
    repeat (3) b_edge();
    check("R2", "b_mb1_empty after FIFO write", W'(b_mb1_empty), W'(1'b1));
    set_b(B_PEEK);
    #1;
    check("R2", "slot 1 untouched by FIFO write", b_dout, D1);
    set_b(IDLE);

    // R2: slot reopens for a new word
    a_cycle(A_MAIL_WR, D3);
    check("R2", "a_mb1_empty after second write", W'(a_mb1_empty), W'(1'b0));
    repeat (2) b_edge();
    set_b(B_PEEK);
    #1;
    check("R2", "slot 1 holds new word", b_dout, D3);
    set_b(B_FIFO_PK);
    #1;
    check("R6", "b_dout shows fifo_q", b_dout, FQ);
    set_b(IDLE);

    // R4: return mailbox
    b_cycle(B_MAIL_WR, D2);
    check("R4", "b_mb2_empty after write", W'(b_mb2_empty), W'(1'b0));
    repeat (2) a_edge();
    check("R4", "a_mb2_empty after crossing", W'(a_mb2_empty), W'(1'b0));
    set_a(A_PEEK);
    #1;
    check("R4", "a_dout shows slot 2", a_dout, D2);
    set_a(IDLE);
    a_cycle(A_MAIL_RD, '0);
    check("R4", "a_mb2_empty after read", W'(a_mb2_empty), W'(1'b1));
    repeat (2) b_edge();
    check("R4", "b_mb2_empty after crossing", W'(b_mb2_empty), W'(1'b1));

    // R6: write direction disables port A output
    set_a(4'b0100);
    #1;
    check("R6", "a_oe in write direction", W'(a_oe), W'(1'b0));
    check("R6", "a_dout in write direction", a_dout, '0);
    set_a(IDLE);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule